// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a received Ethernet frame, presented one byte per handshake, and stores it in memory buffers that software has posted in a ring of two-word descriptors. For each buffer it reads the first descriptor word and checks the ownership flag. It packs the incoming bytes into 32-bit little-endian words and writes them with byte enables. When the frame ends or the buffer is full, it writes the status word and then hands the buffer back to software by setting the ownership flag. A frame longer than one buffer continues in the following descriptors. The ring wraps at a descriptor whose wrap flag is set.

Software programs the ring base address and the first-buffer byte offset, then raises the enable. The buffer size is a fixed parameter, 128 bytes by default, and must be a multiple of four. The memory side is a single-beat master. A request holds address, direction, data and byte enables until the memory answers with an acknowledge, and read data comes with that acknowledge. If a fetched descriptor still belongs to software, the block raises a one-cycle buffer-unavailable pulse and discards what is left of the frame.

Top module: `rxr_ring_dma`

## Requirements
- R1: A rising edge on `rx_en` loads the descriptor pointer from `ring_base`, so the next frame goes to the descriptor at the ring base.
- R2: Descriptor word 0 is decoded as bits 31:2 = word address of the buffer, bit 1 = wrap, bit 0 = ownership. Frame data goes only into a buffer whose fetched ownership bit is 0.
- R3: After a buffer is finished, its word 0 is written back as the same address and wrap bit with bit 0 set to 1. This write comes after the status write.
- R4: After a descriptor with wrap set has been used, the next descriptor is fetched from `ring_base`. Otherwise it is fetched from the current descriptor address plus 8.
- R5: A frame that does not fit one buffer continues in the next descriptors. The status word of every buffer except the last is zero, apart from bit 14 (start of frame), which is 1 in the first buffer.
- R6: The status word (descriptor word 1) of the buffer holding the frame's last byte has bits 12:0 = frame length in bytes, bit 13 = 0, bit 14 = start of frame (set if that buffer is also the first), bit 15 = 1 (end of frame), and bits 31:16 = `in_flags` as sampled with the last byte.
- R7: Byte k of a buffer lands at buffer address + k, in lane k mod 4 of word k/4. In the first buffer of a frame the first data byte lands at byte `first_ofs` (0..3), so that buffer holds BUF_LEN minus `first_ofs` bytes. Later buffers start at byte 0.
- R8: Partial words are written with byte enables, so memory bytes of a buffer that hold no frame data are left unchanged.
- R9: If a fetched word 0 has bit 0 set, `bna` pulses high for one cycle. The rest of the frame is accepted and dropped with no memory write, and the pointer stays on that descriptor, so the next frame fetches it again.
- R10: A frame that ends exactly on the last byte of a buffer does not fetch or touch the next descriptor.
- R11: A memory request keeps its address, direction, write data and byte enables stable until `mem_ack` is seen.
- R12: While `rx_en` is low and no frame is in progress, input bytes are accepted and discarded and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; its rising edge reloads the descriptor pointer |
| ring_base | input | 32 | Byte address of the first descriptor (8-byte aligned) |
| first_ofs | input | 2 | Byte offset of frame data in the first buffer of a frame |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_flags | input | 16 | Frame status flags, sampled with the last byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | Completes the pending request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| bna | output | 1 | One-cycle pulse: fetched descriptor still owned by software |

## Verification
The collision of interest is a frame's last byte that also fills the last byte of a buffer. End of frame and end of buffer then close the same buffer. The block must write the full status and hand the buffer back without opening another descriptor. The bench reaches this by sweeping every frame length from 1 to 40 bytes under each of the four first-buffer offsets, so each length equal to a multiple of the usable size is hit with each offset. For every frame it works out the expected buffer split, bytes, status and ownership words, and confirms that the descriptor after the last used one is untouched. A second overlap is an ownership miss partway through a frame, which comes right after a completed buffer has been handed back. It is provoked by presetting the next descriptor's ownership bit.

// File: rtl/rxr_pkg.sv
// Shared definitions for the receive descriptor ring writer.
// Assumes: 32-bit word memory, descriptor status layout fixed below.
package rxr_pkg;

    localparam int LEN_W   = 13;   // frame length field width in status
    localparam int FLAG_W  = 16;   // frame flags carried in status[31:16]
    localparam int SOF_BIT = 14;
    localparam int EOF_BIT = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RECV,
        ST_WDATA,
        ST_WSTAT,
        ST_WOWN,
        ST_DROP
    } rxr_state_e;

    // Build a descriptor status word for a finished buffer.
    function automatic logic [31:0] rxr_status(
        input logic              last,
        input logic              first,
        input logic [LEN_W-1:0]  len,
        input logic [FLAG_W-1:0] flags
    );
        logic [31:0] s;
        s          = '0;
        s[SOF_BIT] = first;
        if (last) begin
            s[EOF_BIT]     = 1'b1;
            s[LEN_W-1:0]   = len;
            s[31:16]       = flags;
        end
        return s;
    endfunction

endpackage

// File: rtl/rxr_byte_pack.sv
// Byte-to-word packer: collects bytes into the four little-endian lanes
// of one 32-bit word and reports which lanes hold data.
// Assumes: each lane is written at most once between clears; put and
// clear never occur in the same cycle.
module rxr_byte_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        put,
    input  logic [1:0]  lane,
    input  logic [7:0]  din,
    input  logic        clear,
    output logic [31:0] word,
    output logic [3:0]  be
);

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] d_q;
        logic       v_q;

        // Capture the byte for this lane and mark the lane valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (clear) begin
                v_q <= 1'b0;
            end else if (put && lane == 2'(g)) begin
                d_q <= din;
                v_q <= 1'b1;
            end
        end

        assign word[8*g +: 8] = v_q ? d_q : 8'h00;
        assign be[g]          = v_q;

        // R8: a lane is never overwritten before its word has been written.
        p_lane_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
            put && lane == 2'(g) |-> !v_q);
    end

endmodule

// File: rtl/rxr_buf_track.sv
// Buffer fill tracker: byte position inside the current buffer, the
// lane of the next byte, the word offset of the last byte stored, and
// whether the buffer is on its last slot or full.
// Assumes: BUF_LEN is a multiple of 4 and at least 8.
module rxr_buf_track #(
    parameter int BUF_LEN = 128,
    localparam int PW     = $clog2(BUF_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          first,
    input  logic [1:0]    ofs,
    input  logic          put,
    output logic [1:0]    lane,
    output logic [PW-1:0] woff,
    output logic          last_slot,
    output logic          full
);

    logic [PW-1:0] pos_q;
    logic [PW-1:0] woff_q;

    // Position counter: starts at the offset in a frame's first buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (load) begin
            pos_q <= first ? PW'(ofs) : '0;
        end else if (put) begin
            pos_q <= pos_q + PW'(1);
        end
    end

    // Byte offset of the word that holds the most recent byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            woff_q <= '0;
        end else if (put) begin
            woff_q <= {pos_q[PW-1:2], 2'b00};
        end
    end

    assign lane      = pos_q[1:0];
    assign woff      = woff_q;
    assign last_slot = (pos_q == PW'(BUF_LEN - 1));
    assign full      = (pos_q == PW'(BUF_LEN));

    // R7: no byte is stored into a buffer that has no room left.
    p_put_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        put |-> pos_q < PW'(BUF_LEN));

    // R7: the position never runs past the end of the buffer.
    p_pos_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= PW'(BUF_LEN));

endmodule

// File: rtl/rxr_desc_ptr.sv
// Descriptor pointer: holds the address of the current descriptor,
// reloads it from the ring base on an enable rising edge, and steps it
// to the next descriptor or back to the base when a buffer is retired.
// Assumes: ring_base is 8-byte aligned; descriptors are 8 bytes apart.
module rxr_desc_ptr (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [31:0] base,
    input  logic        adv,
    input  logic        wrap,
    output logic [31:0] ptr
);

    logic        en_q;
    logic [31:0] ptr_q;
    logic        reload;

    assign reload = en && !en_q;

    // Remember the enable level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    // Pointer update: reload has priority over a ring step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (reload) begin
            ptr_q <= base;
        end else if (adv) begin
            ptr_q <= wrap ? base : ptr_q + 32'd8;
        end
    end

    assign ptr = ptr_q;

    // R4: the pointer moves only on a retired buffer or an enable edge.
    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv && !reload |=> $stable(ptr_q));

endmodule

// File: rtl/rxr_ring_dma.sv
// Receive descriptor ring writer (top). Fetches a descriptor, checks its
// ownership bit, stores frame bytes as 32-bit words with byte enables,
// splits long frames across buffers, then writes status and hands the
// buffer back. A descriptor still owned by software drops the frame.
// Assumes: single outstanding memory request, data returned with ack.
module rxr_ring_dma
    import rxr_pkg::*;
#(
    parameter int BUF_LEN = 128,
    localparam int PW     = $clog2(BUF_LEN + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic [31:0] ring_base,
    input  logic [1:0]  first_ofs,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic [15:0] in_flags,
    output logic        in_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        bna
);

    rxr_state_e         st_q, st_d;
    logic [31:2]        buf_q;
    logic               wrap_q;
    logic               first_q;
    logic               ended_q;
    logic               bna_q;
    logic [LEN_W-1:0]   flen_q;
    logic [FLAG_W-1:0]  flags_q;

    logic               acc;
    logic               put;
    logic               trk_load;
    logic               adv;
    logic               pk_clear;
    logic               start;
    logic [1:0]         lane;
    logic [PW-1:0]      woff;
    logic               last_slot;
    logic               full;
    logic [31:0]        ptr;
    logic [31:0]        pk_word;
    logic [3:0]         pk_be;

    rxr_desc_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .base  (ring_base),
        .adv   (adv),
        .wrap  (wrap_q),
        .ptr   (ptr)
    );

    rxr_buf_track #(.BUF_LEN(BUF_LEN)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .first     (first_q),
        .ofs       (first_ofs),
        .put       (put),
        .lane      (lane),
        .woff      (woff),
        .last_slot (last_slot),
        .full      (full)
    );

    rxr_byte_pack u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .put   (put),
        .lane  (lane),
        .din   (in_data),
        .clear (pk_clear),
        .word  (pk_word),
        .be    (pk_be)
    );

    // Input handshake: take bytes while receiving, dropping, or disabled.
    always_comb begin
        in_ready = (st_q == ST_RECV) || (st_q == ST_DROP) ||
                   (st_q == ST_IDLE && !rx_en);
    end

    assign acc = in_valid && in_ready;

    // Next-state logic and the one-cycle strobes for the sub-blocks.
    always_comb begin
        st_d     = st_q;
        put      = 1'b0;
        trk_load = 1'b0;
        adv      = 1'b0;
        pk_clear = 1'b0;
        start    = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (rx_en && in_valid) begin
                    st_d  = ST_FETCH;
                    start = 1'b1;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    if (mem_rdata[0]) begin
                        st_d = ST_DROP;
                    end else begin
                        st_d     = ST_RECV;
                        trk_load = 1'b1;
                    end
                end
            end
            ST_RECV: begin
                if (acc) begin
                    put = 1'b1;
                    if (in_last || lane == 2'd3 || last_slot) st_d = ST_WDATA;
                end
            end
            ST_WDATA: begin
                if (mem_ack) begin
                    pk_clear = 1'b1;
                    st_d     = (ended_q || full) ? ST_WSTAT : ST_RECV;
                end
            end
            ST_WSTAT: begin
                if (mem_ack) st_d = ST_WOWN;
            end
            ST_WOWN: begin
                if (mem_ack) begin
                    adv  = 1'b1;
                    st_d = ended_q ? ST_IDLE : ST_FETCH;
                end
            end
            ST_DROP: begin
                if (acc && in_last) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Buffer-unavailable pulse: fetched descriptor still owned by software.
    always_ff @(posedge clk) begin
        if (!rst_n) bna_q <= 1'b0;
        else        bna_q <= (st_q == ST_FETCH) && mem_ack && mem_rdata[0];
    end

    assign bna = bna_q;

    // Latch buffer address and wrap flag from a usable descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            wrap_q <= 1'b0;
        end else if (trk_load) begin
            buf_q  <= mem_rdata[31:2];
            wrap_q <= mem_rdata[1];
        end
    end

    // Frame bookkeeping: first-buffer flag, length, end marker, flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            ended_q <= 1'b0;
            flen_q  <= '0;
            flags_q <= '0;
        end else if (start) begin
            first_q <= 1'b1;
            ended_q <= 1'b0;
            flen_q  <= '0;
        end else begin
            if (adv) first_q <= 1'b0;
            if (put) begin
                flen_q <= flen_q + LEN_W'(1);
                if (in_last) begin
                    ended_q <= 1'b1;
                    flags_q <= in_flags;
                end
            end
        end
    end

    // Memory request decode: one request kind per state, held until ack.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        mem_be    = 4'hF;
        case (st_q)
            ST_FETCH: begin
                mem_req = 1'b1;
            end
            ST_WDATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {buf_q, 2'b00} + 32'(woff);
                mem_wdata = pk_word;
                mem_be    = pk_be;
            end
            ST_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + 32'd4;
                mem_wdata = rxr_status(ended_q, first_q, flen_q, flags_q);
            end
            ST_WOWN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {buf_q, wrap_q, 1'b1};
            end
            default: ;
        endcase
    end

    // R11: an unanswered request stays stable into the next cycle.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) &&
        $stable(mem_we) && $stable(mem_wdata) && $stable(mem_be));

    // R9: dropping a frame never touches memory.
    p_drop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_DROP |-> !mem_req);

    // R9: the unavailable flag is a single-cycle pulse.
    p_bna_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bna_q |=> !bna_q);

    // R8: every write carries at least one enabled byte.
    p_be_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_be != 4'h0);

    // R6: a final status is only written for a frame with bytes in it.
    p_len_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_WSTAT && ended_q |-> flen_q != '0);

endmodule

// File: tb/rxr_ring_dma_tb_top.sv
`timescale 1ns/1ps
module rxr_ring_dma_tb_top;

    localparam int          BUF    = 16;
    localparam logic [31:0] RING   = 32'h40;
    localparam logic [31:0] BUFB   = 32'h100;
    localparam int          STRIDE = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_en;
    logic [31:0] ring_base;
    logic [1:0]  first_ofs;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_last;
    logic [15:0] in_flags;
    logic        in_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        bna;

    logic [31:0] mem [0:255];
    int checks = 0;
    int fails = 0;
    int bna_cnt = 0;
    int req_cnt = 0;
    int wr_cnt = 0;
    int ring_idx = 0;

    always #4 clk = ~clk;

    rxr_ring_dma #(.BUF_LEN(BUF)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
        .first_ofs(first_ofs), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_flags(in_flags), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .bna(bna)
    );

    // Memory model: answers one request every other cycle.
    initial begin
        int a;
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(posedge clk);
            #1;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                a = int'(mem_addr[9:2]);
                if (mem_we) begin
                    for (int l = 0; l < 4; l++)
                        if (mem_be[l]) mem[a][8*l +: 8] = mem_wdata[8*l +: 8];
                    wr_cnt++;
                end else begin
                    mem_rdata = mem[a];
                end
                mem_ack = 1'b1;
            end
        end
    end

    // Monitor of pulses and request cycles, sampled mid-cycle.
    always @(negedge clk) begin
        if (bna) bna_cnt++;
        if (mem_req) req_cnt++;
    end

    function automatic logic [7:0] dbyte(int seed, int k);
        return 8'(seed * 13 + k * 7 + 1);
    endfunction

    function automatic logic [31:0] baddr(int i);
        return BUFB + 32'(i * STRIDE);
    endfunction

    function automatic logic [31:0] w0_init(int i);
        return baddr(i) | ((i == 3) ? 32'h2 : 32'h0);
    endfunction

    function automatic logic [31:0] st_init(int i);
        return 32'h5A5A_0000 | 32'(i);
    endfunction

    function automatic logic [31:0] stat(bit last, bit first, int len, logic [15:0] fl);
        logic [31:0] s;
        s = 32'h0;
        if (first) s = s | 32'h4000;
        if (last)  s = s | 32'h8000 | 32'(len) | {fl, 16'h0};
        return s;
    endfunction

    function automatic logic [7:0] rd_byte(logic [31:0] a);
        return mem[a[9:2]][8*a[1:0] +: 8];
    endfunction

    task automatic init_desc(int i);
        mem[(RING >> 2) + 2*i]     = w0_init(i);
        mem[(RING >> 2) + 2*i + 1] = st_init(i);
        for (int w = 0; w < STRIDE/4; w++) mem[(baddr(i) >> 2) + w] = 32'hA5A5_A5A5;
    endtask

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare one buffer region, its status word and its word 0.
    task automatic check_buf(int i, int p0, int n, int seed, int k0,
                             logic [31:0] st_exp, string req);
        logic [7:0] act, exp, ba, be;
        bit bad;
        bad = 0; ba = 0; be = 0;
        for (int b = 0; b < STRIDE; b++) begin
            exp = (b >= p0 && b < p0 + n) ? dbyte(seed, k0 + b - p0) : 8'hA5;
            act = rd_byte(baddr(i) + 32'(b));
            if (act != exp && !bad) begin bad = 1; ba = act; be = exp; end
        end
        check(!bad, "R2 R7 R8", "buffer bytes", {24'h0, ba}, {24'h0, be});
        check(mem[(RING >> 2) + 2*i + 1] == st_exp, req, "status word",
              mem[(RING >> 2) + 2*i + 1], st_exp);
        check(mem[(RING >> 2) + 2*i] == (w0_init(i) | 32'h1), "R3", "word0 handback",
              mem[(RING >> 2) + 2*i], w0_init(i) | 32'h1);
    endtask

    task automatic send_frame(int len, int seed, logic [15:0] fl);
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1;
            in_data  = dbyte(seed, k);
            in_last  = (k == len - 1);
            in_flags = fl;
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (20) @(posedge clk);
        #1;
    endtask

    // Walk the expected buffer split of a finished frame and restore it.
    task automatic verify_frame(int len, int ofs, int seed, logic [15:0] fl);
        int k, p, i, n;
        bit first, last;
        k = 0; p = ofs; i = ring_idx; first = 1;
        while (k < len) begin
            n = (len - k < BUF - p) ? len - k : BUF - p;
            last = (k + n == len);
            check_buf(i, p, n, seed, k, stat(last, first, len, fl),
                      last ? "R6" : ((i == 0 && k > 0) ? "R4 R5" : "R5"));
            init_desc(i);
            k += n; p = 0; first = 0; i = (i + 1) % 4;
        end
        check(mem[(RING >> 2) + 2*i] == w0_init(i), "R10", "next word0 untouched",
              mem[(RING >> 2) + 2*i], w0_init(i));
        check(mem[(RING >> 2) + 2*i + 1] == st_init(i), "R10", "next status untouched",
              mem[(RING >> 2) + 2*i + 1], st_init(i));
        ring_idx = i;
    endtask

    task automatic run_frame(int len, int ofs, int seed, logic [15:0] fl);
        first_ofs = 2'(ofs);
        send_frame(len, seed, fl);
        verify_frame(len, ofs, seed, fl);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        int b0, r0, w0, j, nx;
        rst_n = 1'b0; rx_en = 1'b0; ring_base = RING; first_ofs = 2'd0;
        in_valid = 1'b0; in_data = 8'h0; in_last = 1'b0; in_flags = 16'h0;
        for (int i = 0; i < 4; i++) init_desc(i);
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req, "R12", "reset mem_req", 32'(mem_req), 0);
        check(!bna, "R9", "reset bna", 32'(bna), 0);
        check(in_ready, "R12", "idle disabled ready", 32'(in_ready), 1);
        @(posedge clk); #1;

        // R12: bytes while disabled are swallowed without memory traffic.
        r0 = req_cnt; w0 = wr_cnt;
        send_frame(8, 3, 16'h0001);
        check(req_cnt == r0, "R12", "requests while disabled", 32'(req_cnt - r0), 0);
        check(mem[(RING >> 2)] == w0_init(0), "R12", "desc0 untouched",
              mem[(RING >> 2)], w0_init(0));

        // R1: enable edge loads the ring base; sweep offsets and lengths.
        rx_en = 1'b1;
        repeat (2) @(posedge clk); #1;
        ring_idx = 0;
        for (int o = 0; o < 4; o++)
            for (int L = 1; L <= 40; L++)
                run_frame(L, o, L + 50 * o, 16'(L * 257 + o));

        // R9: owned descriptor at frame start drops the whole frame.
        mem[(RING >> 2) + 2*ring_idx] = w0_init(ring_idx) | 32'h1;
        b0 = bna_cnt; w0 = wr_cnt;
        first_ofs = 2'd1;
        send_frame(10, 9, 16'hBEEF);
        check(bna_cnt - b0 == 1, "R9", "bna pulses", 32'(bna_cnt - b0), 1);
        check(wr_cnt == w0, "R9", "writes during drop", 32'(wr_cnt - w0), 0);
        check_buf(ring_idx, 0, 0, 0, 0, st_init(ring_idx), "R9");
        init_desc(ring_idx);
        run_frame(10, 1, 11, 16'hC0DE);

        // R9: owned descriptor in mid-frame; pointer stays there.
        j = ring_idx; nx = (j + 1) % 4;
        mem[(RING >> 2) + 2*nx] = w0_init(nx) | 32'h1;
        b0 = bna_cnt;
        first_ofs = 2'd0;
        send_frame(BUF + 5, 77, 16'h1234);
        check(bna_cnt - b0 == 1, "R9", "mid-frame bna", 32'(bna_cnt - b0), 1);
        check_buf(j, 0, BUF, 77, 0, stat(0, 1, 0, 16'h0), "R5");
        check_buf(nx, 0, 0, 0, 0, st_init(nx), "R9");
        init_desc(j); init_desc(nx);
        ring_idx = nx;
        run_frame(5, 2, 21, 16'h00A1);

        // R1: a new enable edge restarts the ring at its base.
        if (ring_idx == 0) run_frame(5, 0, 30, 16'h0002);
        rx_en = 1'b0;
        repeat (2) @(posedge clk); #1;
        rx_en = 1'b1;
        repeat (2) @(posedge clk); #1;
        first_ofs = 2'd3;
        send_frame(9, 40, 16'h0F0F);
        check(mem[(RING >> 2)][0] == 1'b1, "R1", "frame at ring base",
              32'(mem[(RING >> 2)][0]), 1);
        ring_idx = 0;
        verify_frame(9, 3, 40, 16'h0F0F);

        finish_up();
    end

endmodule